// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Processor

This block is a very small processor that runs programs held in its own 32-byte memory. Every instruction is one byte wide. The top three bits select one of eight operations, and the low five bits name a memory location directly. All work is done in one 8-bit accumulator. Each instruction moves through explicit register transfers:

- the program counter feeds the address register;
- memory feeds the data register;
- the data register feeds the instruction register;
- the instruction's address field then steers an operand read or a write.

A test harness works as follows. It holds synchronous reset and fills memory through a side port. It picks the first instruction address on a start input, then releases reset. It waits for the halted flag, then reads results back through the same side port. The program counter and the accumulator are always visible on debug outputs.

Top module: `accpu_core`

## Requirements
- R1: While reset is held, at the next clock edge the program counter takes `startAddr`, the accumulator clears to 0 and `halted` is 0. Memory contents are not changed by reset.
- R2: An instruction byte carries its opcode in bits 7:5 and a direct address in bits 4:0. The opcode values are:
  - 000 halt
  - 001 load
  - 010 store
  - 011 add
  - 100 subtract
  - 101 jump
  - 110 jump-if-zero
  - 111 jump-if-positive
- R3: Load (001) places the byte at the addressed location into the accumulator and advances the program counter by one.
- R4: Add (011) replaces the accumulator with accumulator plus operand, modulo 256. For example, 0x05 plus 0xFD gives 0x02.
- R5: Subtract (100) replaces the accumulator with accumulator minus operand, modulo 256. For example, 0x03 minus 0x05 gives 0xFE.
- R6: Store (010) writes the accumulator to the addressed location and advances the program counter by one.
- R7: Halt (000) raises `halted`. It stays high, with the program counter left at the halt instruction's address and the accumulator unchanged, until reset.
- R8: Jump (101) loads the program counter with the address field.
- R9: Jump-if-zero (110) loads the program counter with the address field when the accumulator is 0x00. Otherwise it advances the program counter by one.
- R10: Jump-if-positive (111) loads the program counter with the address field only when accumulator bit 7 is 0 and the accumulator is nonzero. Otherwise it advances the program counter by one.
- R11: Advancing the program counter from 31 gives 0.
- R12: The side port writes `dbgWdata` to `dbgAddr` at a clock edge when `dbgWe` is 1. `dbgRdata` shows the byte at `dbgAddr` with no clock delay. When a side-port write and a store hit the same location at the same edge, the store's value is kept. When they hit different locations, both writes land.
- R13: Clock edges spent per instruction:
  - load, add and subtract take 6;
  - store takes 5;
  - jumps take 4;
  - halt sets `halted` on its 4th edge.

  A load, add, store, halt program therefore raises `halted` 21 edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| startAddr | input | 5 | Program counter value taken during reset |
| dbgWe | input | 1 | Side-port write enable |
| dbgAddr | input | 5 | Side-port location |
| dbgWdata | input | 8 | Side-port write data |
| dbgRdata | output | 8 | Side-port read data, combinational |
| halted | output | 1 | High once a halt instruction has executed |
| pcView | output | 5 | Current program counter |
| accView | output | 8 | Current accumulator |

## Verification
The memory can take a side-port write and a store write in the same clock edge. Correctness depends on the store winning when both target one location, and on both landing when they do not.

The bench provokes this case by counting edges from reset release. It drives a side-port write exactly on the edge where a store's write step completes, once to the store's own location and once to a different one. After halt it reads both locations back through the side port.

// File: rtl/accpu_pkg.sv
package accpu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_HALT  = 3'b000,
    OP_LOAD  = 3'b001,
    OP_STORE = 3'b010,
    OP_ADD   = 3'b011,
    OP_SUB   = 3'b100,
    OP_JMP   = 3'b101,
    OP_JZ    = 3'b110,
    OP_JPOS  = 3'b111
  } opcode_e;

  typedef struct packed {
    logic marFromPc;
    logic marFromIr;
    logic mdrFromMem;
    logic mdrFromAcc;
    logic irFromMdr;
    logic accLoad;
    logic accAdd;
    logic accSub;
    logic memWrite;
    logic pcInc;
    logic pcJump;
  } ctrl_t;
endpackage

// File: rtl/accpu_control.sv
module accpu_control
  import accpu_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  opcode_e opcode,
  input  logic    accZero,
  input  logic    accNeg,
  output ctrl_t   ctl,
  output logic    halted
);
  typedef enum logic [2:0] {
    S_FADDR, S_FREAD, S_FIR, S_DEC, S_OREAD, S_EXEC, S_WRITE, S_HALT
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FADDR;
    else     state <= nextState;
  end

  always_comb begin
    ctl = '0;
    nextState = state;
    unique case (state)
      S_FADDR: begin ctl.marFromPc  = 1'b1; nextState = S_FREAD; end
      S_FREAD: begin ctl.mdrFromMem = 1'b1; nextState = S_FIR;   end
      S_FIR:   begin ctl.irFromMdr  = 1'b1; nextState = S_DEC;   end
      S_DEC: begin
        unique case (opcode)
          OP_HALT: nextState = S_HALT;
          OP_LOAD, OP_ADD, OP_SUB: begin
            ctl.marFromIr = 1'b1;
            nextState = S_OREAD;
          end
          OP_STORE: begin
            ctl.marFromIr  = 1'b1;
            ctl.mdrFromAcc = 1'b1;
            nextState = S_WRITE;
          end
          OP_JMP: begin ctl.pcJump = 1'b1; nextState = S_FADDR; end
          OP_JZ: begin
            if (accZero) ctl.pcJump = 1'b1;
            else         ctl.pcInc  = 1'b1;
            nextState = S_FADDR;
          end
          OP_JPOS: begin
            if (!accZero && !accNeg) ctl.pcJump = 1'b1;
            else                     ctl.pcInc  = 1'b1;
            nextState = S_FADDR;
          end
        endcase
      end
      S_OREAD: begin ctl.mdrFromMem = 1'b1; nextState = S_EXEC; end
      S_EXEC: begin
        ctl.accLoad = (opcode == OP_LOAD);
        ctl.accAdd  = (opcode == OP_ADD);
        ctl.accSub  = (opcode == OP_SUB);
        ctl.pcInc   = 1'b1;
        nextState   = S_FADDR;
      end
      S_WRITE: begin
        ctl.memWrite = 1'b1;
        ctl.pcInc    = 1'b1;
        nextState    = S_FADDR;
      end
      S_HALT: nextState = S_HALT;
    endcase
  end

  assign halted = (state == S_HALT);

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    halted |-> (ctl == '0));
  assert_one_acc_op_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.accLoad, ctl.accAdd, ctl.accSub}));
  assert_fetch_order_R13: assert property (@(posedge clk) disable iff (rst)
    ctl.irFromMdr |-> $past(ctl.mdrFromMem));
endmodule

// File: rtl/accpu_datapath.sv
module accpu_datapath
  import accpu_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] startAddr,
  input  ctrl_t             ctl,
  input  logic              dbgWe,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic [OP_W+ADDR_W-1:0] dbgWdata,
  output logic [OP_W+ADDR_W-1:0] dbgRdata,
  output opcode_e           opcode,
  output logic              accZero,
  output logic              accNeg,
  output logic [ADDR_W-1:0] pcOut,
  output logic [OP_W+ADDR_W-1:0] accOut
);
  localparam int DATA_W = OP_W + ADDR_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] ir, mdr, acc;
  logic [ADDR_W-1:0] irAddr;

  assign irAddr = ir[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= startAddr;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
      acc <= '0;
    end else begin
      if (ctl.marFromPc)       mar <= pc;
      else if (ctl.marFromIr)  mar <= irAddr;
      if (ctl.mdrFromMem)      mdr <= mem[mar];
      else if (ctl.mdrFromAcc) mdr <= acc;
      if (ctl.irFromMdr)       ir  <= mdr;
      if (ctl.accLoad)         acc <= mdr;
      else if (ctl.accAdd)     acc <= acc + mdr;
      else if (ctl.accSub)     acc <= acc - mdr;
      if (ctl.pcJump)          pc  <= irAddr;
      else if (ctl.pcInc)      pc  <= pc + 1'b1;
    end
  end

  // Side-port write first, so a same-edge store to that location overrides it.
  always_ff @(posedge clk) begin
    if (dbgWe)        mem[dbgAddr] <= dbgWdata;
    if (ctl.memWrite) mem[mar]     <= mdr;
  end

  assign dbgRdata = mem[dbgAddr];
  assign opcode   = opcode_e'(ir[DATA_W-1 -: OP_W]);
  assign accZero  = (acc == '0);
  assign accNeg   = acc[DATA_W-1];
  assign pcOut    = pc;
  assign accOut   = acc;

  assert_store_lands_R6: assert property (@(posedge clk) disable iff (rst)
    ctl.memWrite |=> mem[$past(mar)] == $past(mdr));
  assert_pc_step_wrap_R11: assert property (@(posedge clk) disable iff (rst)
    ctl.pcInc |=> pc == $past(pc) + 1'b1);
  assert_jump_target_R8: assert property (@(posedge clk) disable iff (rst)
    ctl.pcJump |=> pc == $past(irAddr));
  assert_ir_from_mdr_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.irFromMdr |=> ir == $past(mdr));
endmodule

// File: rtl/accpu_core.sv
module accpu_core
  import accpu_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int DATA_W = OP_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              dbgWe,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic [DATA_W-1:0] dbgWdata,
  output logic [DATA_W-1:0] dbgRdata,
  output logic              halted,
  output logic [ADDR_W-1:0] pcView,
  output logic [DATA_W-1:0] accView
);
  ctrl_t   ctl;
  opcode_e opcode;
  logic    accZero, accNeg;

  accpu_control u_control (
    .clk(clk), .rst(rst), .opcode(opcode), .accZero(accZero),
    .accNeg(accNeg), .ctl(ctl), .halted(halted)
  );

  accpu_datapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk(clk), .rst(rst), .startAddr(startAddr), .ctl(ctl),
    .dbgWe(dbgWe), .dbgAddr(dbgAddr), .dbgWdata(dbgWdata),
    .dbgRdata(dbgRdata), .opcode(opcode), .accZero(accZero),
    .accNeg(accNeg), .pcOut(pcView), .accOut(accView)
  );
endmodule

// File: tb/accpu_core_test.sv
`timescale 1ns/1ps
module accpu_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] startAddr = '0;
  logic       dbgWe = 1'b0;
  logic [4:0] dbgAddr = '0;
  logic [7:0] dbgWdata = '0;
  logic [7:0] dbgRdata;
  logic       halted;
  logic [4:0] pcView;
  logic [7:0] accView;

  int nChecks = 0;
  int nFails  = 0;

  accpu_core uut (
    .clk(clk), .rst(rst), .startAddr(startAddr), .dbgWe(dbgWe),
    .dbgAddr(dbgAddr), .dbgWdata(dbgWdata), .dbgRdata(dbgRdata),
    .halted(halted), .pcView(pcView), .accView(accView)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Entered at a negedge; holds reset, fills memory with zeros.
  task automatic resetAndClear(input logic [4:0] start);
    rst = 1'b1;
    startAddr = start;
    for (int i = 0; i < 32; i++) begin
      dbgWe = 1'b1; dbgAddr = 5'(i); dbgWdata = 8'h00;
      @(negedge clk);
    end
    dbgWe = 1'b0;
  endtask

  task automatic poke(input logic [4:0] a, input logic [7:0] d);
    dbgWe = 1'b1; dbgAddr = a; dbgWdata = d;
    @(negedge clk);
    dbgWe = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [7:0] d);
    dbgAddr = a;
    #0.5;
    d = dbgRdata;
  endtask

  task automatic runToHalt(output int edges);
    rst = 1'b0;
    edges = 0;
    for (int k = 0; k < 400; k++) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (halted) break;
    end
  endtask

  task automatic testMainProgram();
    int e; logic [7:0] v;
    resetAndClear(5'd4);
    poke(5'd4, 8'h28); poke(5'd5, 8'h69); poke(5'd6, 8'h4A); poke(5'd7, 8'h00);
    poke(5'd8, 8'h05); poke(5'd9, 8'hFD);
    peek(5'd9, v);
    check("R12 side-port readback", v, 8'hFD);
    runToHalt(e);
    check("R13 edges to halt", e, 21);
    check("R7 halted", halted, 1);
    check("R4 add wraps", accView, 8'h02);
    peek(5'd10, v);
    check("R6 stored result", v, 8'h02);
    check("R7 pc at halt", pcView, 7);
    repeat (10) @(negedge clk);
    check("R7 halt sticky", halted, 1);
    check("R7 pc holds", pcView, 7);
    check("R7 acc holds", accView, 8'h02);
  endtask

  task automatic testReset();
    rst = 1'b1; startAddr = 5'd4;
    @(negedge clk);
    check("R1 pc from start", pcView, 4);
    check("R1 acc cleared", accView, 0);
    check("R1 halted low", halted, 0);
    startAddr = 5'd19;
    @(negedge clk);
    check("R1 pc from new start", pcView, 19);
  endtask

  task automatic testSub();
    int e; logic [7:0] v;
    resetAndClear(5'd0);
    poke(5'd0, 8'h34); poke(5'd1, 8'h95); poke(5'd2, 8'h56); poke(5'd3, 8'h00);
    poke(5'd20, 8'h03); poke(5'd21, 8'h05);
    runToHalt(e);
    check("R5 subtract wraps", accView, 8'hFE);
    peek(5'd22, v);
    check("R6 store of difference", v, 8'hFE);
    check("R3 load then sub edges", e, 21);
  endtask

  task automatic testJump();
    int e;
    resetAndClear(5'd0);
    poke(5'd0, 8'hA8); poke(5'd8, 8'h34); poke(5'd20, 8'h11);
    runToHalt(e);
    check("R8 jump pc", pcView, 9);
    check("R3 load after jump", accView, 8'h11);
    check("R13 jump edges", e, 4 + 6 + 4);
  endtask

  task automatic condProg(input logic [7:0] br, input logic [7:0] data,
                          output logic [4:0] pcEnd);
    int e;
    resetAndClear(5'd0);
    poke(5'd0, 8'h34); poke(5'd1, br); poke(5'd20, data);
    runToHalt(e);
    pcEnd = pcView;
  endtask

  task automatic testCondJumps();
    logic [4:0] p;
    condProg(8'hC5, 8'h00, p); check("R9 jz taken", p, 5);
    condProg(8'hC5, 8'h01, p); check("R9 jz not taken", p, 2);
    condProg(8'hE5, 8'h01, p); check("R10 jpos taken", p, 5);
    condProg(8'hE5, 8'h00, p); check("R10 jpos zero not taken", p, 2);
    condProg(8'hE5, 8'h80, p); check("R10 jpos negative not taken", p, 2);
    condProg(8'hE5, 8'h7F, p); check("R10 jpos max positive", p, 5);
  endtask

  task automatic testWrap();
    int e;
    resetAndClear(5'd31);
    poke(5'd31, 8'h34); poke(5'd20, 8'h42);
    runToHalt(e);
    check("R11 pc wraps to 0", pcView, 0);
    check("R11 load at 31", accView, 8'h42);
  endtask

  // Store write completes on edge 11 after release.
  task automatic collide(input logic [4:0] sideAddr);
    logic [7:0] v;
    resetAndClear(5'd0);
    poke(5'd0, 8'h34); poke(5'd1, 8'h55); poke(5'd20, 8'h37);
    rst = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    dbgWe = 1'b1; dbgAddr = sideAddr; dbgWdata = 8'h99;
    @(negedge clk);
    dbgWe = 1'b0;
    for (int k = 0; k < 50 && !halted; k++) @(negedge clk);
    check("R7 collision run halts", halted, 1);
    peek(5'd21, v);
    check("R12 store location", v, 8'h37);
    if (sideAddr != 5'd21) begin
      peek(sideAddr, v);
      check("R12 side write lands", v, 8'h99);
    end
  endtask

  initial begin
    #(200000 * 4);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    testMainProgram();
    testReset();
    testSub();
    testJump();
    testCondJumps();
    testWrap();
    collide(5'd21);
    collide(5'd25);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule